// File: doc/BRIEF.md
# Aligned watch range decomposer

This block turns a request to watch an arbitrary byte range (a start address and a byte length) into a short list of watch chunks. Each chunk is 1, 2 or 4 bytes long and starts at an address that is a multiple of its own size. Together the chunks cover the requested bytes exactly and touch nothing outside them, so a watch unit programmed from the list never fires on an access to a neighbouring variable.

A request is taken on a valid/ready handshake. The chunks then stream out in ascending address order, one per output handshake, and the final one carries a last flag. Only a fixed number of watch slots exists (four by default). A request that would need more chunks than that produces no chunks. Instead it raises a one-cycle status pulse with an overflow flag. A zero-length request gets the same kind of status pulse with an empty flag. No new request is taken until the current chunk list has drained.

Top module: `wp_range_split`

## Requirements
- R1: Every chunk has a size of 1, 2 or 4 bytes and is aligned to that size. The size appears on `chk_code` as 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. Code 3 never appears.
- R2: The chunks of one request are contiguous and ascending. The first starts at `req_addr`, and their sizes sum exactly to `req_len`.
- R3: Each chunk is the largest size that is aligned at the current address and does not exceed the bytes still to be covered. For example, 3 bytes at a 4-aligned address give 2 then 1, and 4 bytes at an address equal to 2 modulo 4 give 2 then 2.
- R4: `chk_last` is 1 on the final chunk of a request and 0 on every other chunk. After the final chunk is taken, `chk_valid` is 0 in the next cycle.
- R5: A request that needs more than MAX_CHUNKS (4) chunks emits no chunk. One cycle after acceptance, `stat_valid`=1 and `stat_overflow`=1 for exactly one cycle.
- R6: A request with `req_len`=0 emits no chunk. One cycle after acceptance, `stat_valid`=1 and `stat_empty`=1 for exactly one cycle.
- R7: `req_ready` is 0 while any chunk of the current request is pending. A request offered during that time is ignored and produces no chunks.
- R8: While `chk_valid`=1 and `chk_ready`=0, the chunk's address, code and last flag stay unchanged and `chk_valid` stays 1.
- R9: After reset, `req_ready`=1, `chk_valid`=0 and `stat_valid`=0. A reset during emission discards the pending chunks.
- R10: The first chunk of an accepted request is valid in the cycle after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Start byte address of the range |
| req_len | input | LEN_W | Length of the range in bytes |
| chk_valid | output | 1 | Chunk on the output is valid |
| chk_ready | input | 1 | Consumer takes the chunk |
| chk_addr | output | ADDR_W | Chunk start address |
| chk_code | output | 2 | Chunk size code (0: 1 B, 1: 2 B, 2: 4 B) |
| chk_last | output | 1 | Final chunk of the request |
| stat_valid | output | 1 | One-cycle status pulse for a rejected request |
| stat_empty | output | 1 | Status: zero-length request |
| stat_overflow | output | 1 | Status: more chunks needed than slots exist |

## Verification
On every cycle the embedded properties check chunk alignment and legal size codes, a non-zero remainder whenever a chunk is offered, stability of a stalled chunk, the drop of `chk_valid` after a last chunk, and that a status pulse never coincides with a chunk. Whether the chunk list is the greedy one, whether it covers exactly the requested bytes, and where the overflow boundary lies can only be shown by the bench's scenarios. These compare whole chunk lists against hand-computed lists for aligned, misaligned, exact-fit and one-too-many ranges. The bench scenarios also show that requests offered during a drain are ignored and that a reset mid-stream discards pending chunks.

// File: rtl/wpd_pkg.sv
package wpd_pkg;

    localparam int ADDR_W_DEF     = 32;
    localparam int LEN_W_DEF      = 8;
    localparam int MAX_CHUNKS_DEF = 4;

    // chunk size as log2 of its byte count
    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2
    } sz_code_e;

    // status of a request that yields no chunks
    typedef struct packed {
        logic valid;
        logic empty;
        logic overflow;
    } stat_t;

    // largest size aligned at 'lo' that fits within the remainder
    function automatic sz_code_e pick_size(input logic [1:0] lo,
                                           input logic ge2,
                                           input logic ge4);
        if (lo == 2'b00 && ge4)
            return SZ_B4;
        else if (!lo[0] && ge2)
            return SZ_B2;
        else
            return SZ_B1;
    endfunction

    function automatic logic [2:0] size_bytes(input sz_code_e c);
        return 3'd1 << c;
    endfunction

endpackage

// File: rtl/wpd_fit.sv
module wpd_fit
    import wpd_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int LEN_W      = LEN_W_DEF,
    parameter int MAX_CHUNKS = MAX_CHUNKS_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              fits
);

    // Walk the greedy split for MAX_CHUNKS steps; the range fits if
    // nothing is left afterwards.
    always_comb begin
        logic [1:0]       lo;
        logic [LEN_W-1:0] rem;
        sz_code_e         c;
        lo  = addr[1:0];
        rem = len;
        c   = SZ_B1;
        for (int i = 0; i < MAX_CHUNKS; i++) begin
            if (rem != '0) begin
                c   = pick_size(lo, rem >= LEN_W'(2), rem >= LEN_W'(4));
                lo  = lo + 2'(size_bytes(c));
                rem = rem - LEN_W'(size_bytes(c));
            end
        end
        fits = (rem == '0);
    end

endmodule

// File: rtl/wpd_stepper.sv
module wpd_stepper
    import wpd_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int LEN_W  = LEN_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              advance,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output sz_code_e          cur_code,
    output logic              cur_last
);

    logic [LEN_W-1:0] rem;
    logic [2:0]       nbytes;

    always_comb begin
        cur_code = pick_size(cur_addr[1:0], rem >= LEN_W'(2), rem >= LEN_W'(4));
        nbytes   = size_bytes(cur_code);
        cur_last = (rem == LEN_W'(nbytes));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cur_addr <= '0;
            rem      <= '0;
        end else if (load) begin
            busy     <= 1'b1;
            cur_addr <= load_addr;
            rem      <= load_len;
        end else if (busy && advance) begin
            cur_addr <= cur_addr + ADDR_W'(nbytes);
            rem      <= rem - LEN_W'(nbytes);
            if (cur_last)
                busy <= 1'b0;
        end
    end

    // R1
    aligned_chunk_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cur_code != 2'd3)
              && (cur_code != SZ_B4 || cur_addr[1:0] == 2'b00)
              && (cur_code != SZ_B2 || !cur_addr[0]));

    // R2
    rem_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> rem != '0);

endmodule

// File: rtl/wp_range_split.sv
module wp_range_split
    import wpd_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int LEN_W      = LEN_W_DEF,
    parameter int MAX_CHUNKS = MAX_CHUNKS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              chk_valid,
    input  logic              chk_ready,
    output logic [ADDR_W-1:0] chk_addr,
    output logic [1:0]        chk_code,
    output logic              chk_last,
    output logic              stat_valid,
    output logic              stat_empty,
    output logic              stat_overflow
);

    logic     fits;
    logic     busy;
    logic     accept;
    logic     is_empty;
    sz_code_e code;
    stat_t    stat_q;

    wpd_fit #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .MAX_CHUNKS(MAX_CHUNKS)
    ) fit_i (
        .addr(req_addr),
        .len (req_len),
        .fits(fits)
    );

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign is_empty  = (req_len == '0);

    wpd_stepper #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) step_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept && !is_empty && fits),
        .load_addr(req_addr),
        .load_len (req_len),
        .advance  (chk_ready),
        .busy     (busy),
        .cur_addr (chk_addr),
        .cur_code (code),
        .cur_last (chk_last)
    );

    assign chk_valid = busy;
    assign chk_code  = code;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.valid    <= accept && (is_empty || !fits);
            stat_q.empty    <= accept && is_empty;
            stat_q.overflow <= accept && !is_empty && !fits;
        end
    end

    assign stat_valid    = stat_q.valid;
    assign stat_empty    = stat_q.empty;
    assign stat_overflow = stat_q.overflow;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        chk_valid && !chk_ready |=> chk_valid && $stable(chk_addr)
                                  && $stable(chk_code) && $stable(chk_last));

    // R4
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        chk_valid && chk_ready && chk_last |=> !chk_valid);

    // R5
    no_chunk_on_stat_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> !chk_valid && (stat_empty != stat_overflow));

    // R6
    stat_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |=> !stat_valid);

endmodule

// File: tb/wp_range_split_tb_top.sv
module wp_range_split_tb_top;

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  len;
        logic [1:0]  kind;   // 0 chunks, 1 overflow, 2 empty
        logic [2:0]  n;
        logic [7:0]  codes;  // chunk j code in bits [2j+1:2j]
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h100, 8'd3,  2'd0, 3'd2, 8'b00_00_00_01},
        '{32'h102, 8'd4,  2'd0, 3'd2, 8'b00_00_01_01},
        '{32'h101, 8'd4,  2'd0, 3'd3, 8'b00_00_01_00},
        '{32'h200, 8'd4,  2'd0, 3'd1, 8'b00_00_00_10},
        '{32'h201, 8'd8,  2'd0, 3'd4, 8'b00_10_01_00},
        '{32'h203, 8'd1,  2'd0, 3'd1, 8'b00_00_00_00},
        '{32'h300, 8'd12, 2'd0, 3'd3, 8'b00_10_10_10},
        '{32'h301, 8'd10, 2'd1, 3'd0, 8'b00_00_00_00},
        '{32'h000, 8'd0,  2'd2, 3'd0, 8'b00_00_00_00},
        '{32'h007, 8'd2,  2'd0, 3'd2, 8'b00_00_00_00},
        '{32'h010, 8'd16, 2'd0, 3'd4, 8'b10_10_10_10},
        '{32'h010, 8'd17, 2'd1, 3'd0, 8'b00_00_00_00},
        '{32'h006, 8'd6,  2'd0, 3'd2, 8'b00_00_10_01}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [7:0]  req_len;
    logic        chk_valid;
    logic        chk_ready;
    logic [31:0] chk_addr;
    logic [1:0]  chk_code;
    logic        chk_last;
    logic        stat_valid;
    logic        stat_empty;
    logic        stat_overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wp_range_split dut_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .chk_valid    (chk_valid),
        .chk_ready    (chk_ready),
        .chk_addr     (chk_addr),
        .chk_code     (chk_code),
        .chk_last     (chk_last),
        .stat_valid   (stat_valid),
        .stat_empty   (stat_empty),
        .stat_overflow(stat_overflow)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic send(input logic [31:0] a, input logic [7:0] l);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_len   = l;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // drain and compare an expected chunk list; optional stall per chunk
    task automatic drain(input vec_t v, input bit stall);
        logic [31:0] a;
        a = v.addr;
        for (int j = 0; j < int'(v.n); j++) begin
            logic [1:0] c;
            bit lst;
            c   = v.codes[2*j +: 2];
            lst = (j == int'(v.n) - 1);
            check(chk_valid == 1'b1, "R10 chunk valid", 32'(chk_valid), 32'd1);
            check(chk_addr == a, "R2 chunk address", chk_addr, a);
            check(chk_code == c, "R3 chunk code", 32'(chk_code), 32'(c));
            check(chk_last == lst, "R4 last flag", 32'(chk_last), 32'(lst));
            check(req_ready == 1'b0, "R7 busy", 32'(req_ready), 32'd0);
            if (stall) begin
                chk_ready = 1'b0;
                @(negedge clk);
                check(chk_valid && chk_addr == a && chk_code == c,
                      "R8 stalled chunk held", chk_addr, a);
            end
            chk_ready = 1'b1;
            @(negedge clk);
            chk_ready = 1'b0;
            a = a + (32'd1 << c);
        end
        check(a == v.addr + 32'(v.len), "R2 coverage sum", a, v.addr + 32'(v.len));
        check(chk_valid == 1'b0, "R4 idle after last", 32'(chk_valid), 32'd0);
        check(req_ready == 1'b1, "R7 ready after drain", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_addr = '0;
        req_len = '0;
        chk_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        check(req_ready == 1'b1, "R9 ready", 32'(req_ready), 32'd1);
        check(chk_valid == 1'b0, "R9 no chunk", 32'(chk_valid), 32'd0);
        check(stat_valid == 1'b0, "R9 no status", 32'(stat_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            send(v.addr, v.len);
            if (v.kind == 2'd0) begin
                check(stat_valid == 1'b0, "R5 no status on fit", 32'(stat_valid), 32'd0);
                drain(v, i[0]);
            end else begin
                check(stat_valid == 1'b1, "R5 R6 status pulse", 32'(stat_valid), 32'd1);
                check(stat_overflow == (v.kind == 2'd1), "R5 overflow flag",
                      32'(stat_overflow), 32'(v.kind == 2'd1));
                check(stat_empty == (v.kind == 2'd2), "R6 empty flag",
                      32'(stat_empty), 32'(v.kind == 2'd2));
                check(chk_valid == 1'b0, "R5 R6 no chunk", 32'(chk_valid), 32'd0);
                @(negedge clk);
                check(stat_valid == 1'b0, "R5 R6 pulse one cycle", 32'(stat_valid), 32'd0);
                check(chk_valid == 1'b0, "R5 R6 still no chunk", 32'(chk_valid), 32'd0);
            end
        end

        // R7: a request offered mid-stream is ignored
        send(32'h400, 8'd3);
        req_valid = 1'b1;
        req_addr  = 32'h500;
        req_len   = 8'd4;
        @(negedge clk);
        req_valid = 1'b0;
        drain('{32'h400, 8'd3, 2'd0, 3'd2, 8'b00_00_00_01}, 1'b0);
        @(negedge clk);
        check(chk_valid == 1'b0, "R7 ignored request left no chunk", 32'(chk_valid), 32'd0);

        // R9: reset mid-stream discards pending chunks
        send(32'h600, 8'd12);
        check(chk_valid == 1'b1, "R10 first chunk after accept", 32'(chk_valid), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(chk_valid == 1'b0, "R9 reset drops chunks", 32'(chk_valid), 32'd0);
        check(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);

        // R1: a single byte at odd address, then a word at aligned address
        send(32'h801, 8'd1);
        check(chk_code == 2'd0 && chk_last, "R1 one-byte code", 32'(chk_code), 32'd0);
        chk_ready = 1'b1;
        @(negedge clk);
        chk_ready = 1'b0;
        send(32'h804, 8'd4);
        check(chk_code == 2'd2 && chk_addr == 32'h804, "R1 word code", 32'(chk_code), 32'd2);
        chk_ready = 1'b1;
        @(negedge clk);
        chk_ready = 1'b0;
        check(chk_valid == 1'b0, "R4 single chunk ends", 32'(chk_valid), 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule